// File: doc/BRIEF.md
# Smart card character UART

This block moves characters over the single bidirectional I/O contact of an asynchronous smart card. The line is open-drain: the block pulls it low through `io_oe`, and `io_in` returns the resolved level. Only one direction runs at a time, and `tx_mode` selects it. The bit period (one ETU) is a whole number of card clock cycles set by `etu_div`. A character is one low start bit, eight data bits sent least significant bit first, and an even parity bit.

In the block-oriented protocol (T=1), characters simply follow one another with the minimum spacing. In the character protocol (T=0), a parity failure is signalled by pulling the line low after the parity bit. The transmitter watches for that signal and resends the character until a programmable retry budget runs out. A force-inverse-parity setting deliberately breaks parity in both directions so that error paths can be exercised. Received characters go into a small FIFO whose usable length is programmable. A four-bit status word reports errors and a direction-dependent ready flag.

Top module: `sc_char_uart`

## Requirements
- R1: After reset, `status` is 0, `rx_cnt` is 0 and `io_oe` is low.
- R2: A write of `tx_data` while transmit mode is selected and the block is idle starts a frame in the next cycle. The frame is a low start bit, then data bit 0 through data bit 7, then the parity bit, where parity = XOR of the data bits. Each bit lasts `etu_div` cycles, and a 0 is sent by asserting `io_oe`.
- R3: After a frame starts, the block stays busy for G·`etu_div` + floor(4·`etu_div`/5) cycles, with `io_oe` low after the parity bit. G is 11 in T=0 and 10 in T=1, plus `guard_etu`. This gives 11.8 ETU (T=0) or 10.8 ETU (T=1) plus the extra guard ETUs.
- R4: A falling edge on `io_in` in receive mode starts a character, and each bit is sampled half an ETU into its period. If the line is high at the start-bit sample, the character is abandoned and nothing is stored or flagged.
- R5: In T=0, a received character whose parity is wrong is not stored. The receiver asserts `io_oe` from 10.5 to 11.5 ETU after the start edge, and sets the parity error flag.
- R6: In T=0, the transmitter samples the line at 10.5 ETU. If the line is low, it resends the same frame after the R3 spacing, up to `retry_max` times. If the last permitted attempt is also refused, the parity error flag is set.
- R7: When `inv_par` is 1, transmitted parity bits are inverted. In that mode a T=0 receiver refuses correctly received characters and stores characters whose parity is wrong.
- R8: The receive FIFO holds `fifo_len`+1 characters and delivers them in arrival order. A character that completes while the FIFO is full is discarded and sets the overrun flag. `rx_cnt` changes by at most one per cycle.
- R9: `status` is {parity error, overrun, framing error, ready}, from bit 3 down to bit 0. In receive mode, ready means the FIFO is full. A pulse on `rd_status` clears bits 3 to 1.
- R10: In transmit mode, ready is set when the block switches from receive to transmit, is cleared by a write, and is set when a character's spacing ends. It is not set if that character was written with `last_char` high.
- R11: In T=1, the receiver never drives the line. A character with bad parity is stored and sets the parity error flag. A low level at 10.5 ETU sets the framing error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | card clock |
| rst_n | input | 1 | active-low reset |
| etu_div | input | ETU_W | card clock cycles per ETU |
| guard_etu | input | GUARD_W | extra ETUs of spacing after each character |
| proto_t1 | input | 1 | 1 = T=1, 0 = T=0 |
| inv_par | input | 1 | force inverse parity |
| retry_max | input | 3 | resends allowed after a refusal in T=0 |
| fifo_len | input | 3 | receive FIFO holds this value plus one |
| tx_mode | input | 1 | 1 = transmit direction, 0 = receive |
| wr_tx | input | 1 | write strobe for `tx_data` |
| tx_data | input | 8 | character to send, direct convention |
| last_char | input | 1 | marks the written character as the last one |
| rd_rx | input | 1 | pop the FIFO head |
| rx_data | output | 8 | FIFO head |
| rx_cnt | output | CNT_W | characters in the FIFO |
| rd_status | input | 1 | clear the error flags |
| status | output | 4 | {parity error, overrun, framing error, ready} |
| io_in | input | 1 | resolved card I/O level |
| io_oe | output | 1 | pull card I/O low |

## Verification
Some properties are checked on every cycle. The FIFO count never exceeds the programmed length and never moves by more than one per cycle. Overrun appears only when the FIFO was full. The line stays undriven while receiving in T=1. Ready is raised on every switch into transmit mode. Other behaviour only shows up in the bench's scenarios: the exact frame waveform, where the spacing ends, the refusal window, the retry count, the effects of inverse parity, and the ordering of the stored data. These need a card model that drives and watches the line across whole characters.

// File: rtl/sc_char_uart.sv
module sc_char_uart #(
  parameter int ETU_W = 8,
  parameter int GUARD_W = 8,
  parameter int FIFO_DEPTH = 8,
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1),
  localparam int PTR_W = $clog2(FIFO_DEPTH),
  localparam int BI_W = GUARD_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ETU_W-1:0] etu_div,
  input  logic [GUARD_W-1:0] guard_etu,
  input  logic             proto_t1,
  input  logic             inv_par,
  input  logic [2:0]       retry_max,
  input  logic [2:0]       fifo_len,
  input  logic             tx_mode,
  input  logic             wr_tx,
  input  logic [7:0]       tx_data,
  input  logic             last_char,
  input  logic             rd_rx,
  output logic [7:0]       rx_data,
  output logic [CNT_W-1:0] rx_cnt,
  input  logic             rd_status,
  output logic [3:0]       status,
  input  logic             io_in,
  output logic             io_oe
);
  logic busy_tx, busy_rx, tx_mode_q, io_q, nak_hit, last_q, tbe;
  logic rx_bad, rx_perr, pe, ovr, fer;
  logic [ETU_W-1:0] ec;
  logic [BI_W-1:0] bi;
  logic [15:0] txf;
  logic [2:0] rc;
  logic [7:0] sh;
  logic [7:0] mem [FIFO_DEPTH];
  logic [PTR_W-1:0] wp, rp;
  logic [CNT_W-1:0] cnt;

  wire [ETU_W-1:0] half = etu_div >> 1;
  wire [ETU_W-1:0] frac = ETU_W'(({3'b000, etu_div} << 2) / 5);
  wire [BI_W-1:0] gap_bi = (proto_t1 ? BI_W'(10) : BI_W'(11)) + BI_W'(guard_etu);
  wire mid = ec == half;
  wire ec_wrap = ec == etu_div - 1'b1;
  wire tx_end = busy_tx && bi == gap_bi && ec == frac - 1'b1;
  wire rx_end = busy_rx && mid && bi == (proto_t1 ? BI_W'(10) : BI_W'(11));
  wire full = cnt == CNT_W'(fifo_len) + 1'b1;
  wire push = rx_end && !rx_bad && !full;
  wire pop = rd_rx && cnt != '0;
  wire nak_win = (bi == BI_W'(10) && ec >= half) || (bi == BI_W'(11) && ec < half);

  assign io_oe = (busy_tx && bi < BI_W'(10) && !txf[bi[3:0]]) || (busy_rx && rx_bad && nak_win);
  assign status = {pe, ovr, fer, tx_mode ? tbe : full};
  assign rx_data = mem[rp];
  assign rx_cnt = cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_tx <= 1'b0; busy_rx <= 1'b0; tx_mode_q <= 1'b0; io_q <= 1'b1;
      nak_hit <= 1'b0; last_q <= 1'b0; tbe <= 1'b0; rx_bad <= 1'b0; rx_perr <= 1'b0;
      pe <= 1'b0; ovr <= 1'b0; fer <= 1'b0;
      ec <= '0; bi <= '0; txf <= '1; rc <= '0; sh <= '0;
    end else begin
      tx_mode_q <= tx_mode;
      io_q <= io_in;
      if (rd_status) begin
        pe <= 1'b0; ovr <= 1'b0; fer <= 1'b0;
      end
      if (busy_tx || busy_rx) begin
        if (ec_wrap) begin
          ec <= '0;
          bi <= bi + 1'b1;
        end else ec <= ec + 1'b1;
      end
      if (busy_tx) begin
        if (!proto_t1 && bi == BI_W'(10) && mid && !io_in) nak_hit <= 1'b1;
        if (tx_end) begin
          bi <= '0; ec <= '0; nak_hit <= 1'b0;
          if (nak_hit && rc < retry_max) rc <= rc + 1'b1;
          else begin
            busy_tx <= 1'b0;
            tbe <= !last_q;
            if (nak_hit) pe <= 1'b1;
          end
        end
      end else if (busy_rx) begin
        if (mid) begin
          if (bi == '0 && io_in) busy_rx <= 1'b0;
          if (bi >= BI_W'(1) && bi <= BI_W'(8)) sh <= {io_in, sh[7:1]};
          if (bi == BI_W'(9)) begin
            rx_perr <= ^sh ^ io_in;
            rx_bad <= !proto_t1 && (^sh ^ io_in ^ inv_par);
          end
          if (bi == BI_W'(10) && (proto_t1 || !rx_bad) && !io_in) fer <= 1'b1;
        end
        if (rx_end) begin
          busy_rx <= 1'b0;
          if (rx_bad || (proto_t1 && rx_perr)) pe <= 1'b1;
          if (!rx_bad && full) ovr <= 1'b1;
        end
      end else if (tx_mode && wr_tx) begin
        busy_tx <= 1'b1; bi <= '0; ec <= '0; rc <= '0; nak_hit <= 1'b0;
        txf <= {6'h3f, ^tx_data ^ inv_par, tx_data, 1'b0};
        tbe <= 1'b0;
        last_q <= last_char;
      end else if (!tx_mode && io_q && !io_in) begin
        busy_rx <= 1'b1; bi <= '0; ec <= '0; rx_bad <= 1'b0; rx_perr <= 1'b0;
      end
      if (tx_mode && !tx_mode_q) tbe <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= sh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop) rp <= rp + 1'b1;
      case ({push, pop})
        2'b10: cnt <= cnt + 1'b1;
        2'b01: cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/sc_char_uart_chk.sv
module sc_char_uart_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tx_mode,
  input logic             proto_t1,
  input logic [2:0]       fifo_len,
  input logic [CNT_W-1:0] rx_cnt,
  input logic [3:0]       status,
  input logic             io_oe
);
  assert_fifo_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= CNT_W'(fifo_len) + 1'b1);

  assert_fifo_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt == $past(rx_cnt) || rx_cnt == $past(rx_cnt) + 1'b1 || rx_cnt == $past(rx_cnt) - 1'b1);

  assert_ovr_when_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[2]) |-> $past(rx_cnt) == CNT_W'(fifo_len) + 1'b1);

  assert_t1_rx_silent_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_mode && proto_t1) |-> !io_oe);

  assert_ready_on_switch_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_mode) |=> status[0]);
endmodule

bind sc_char_uart sc_char_uart_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_mode(tx_mode), .proto_t1(proto_t1),
  .fifo_len(fifo_len), .rx_cnt(rx_cnt), .status(status), .io_oe(io_oe)
);

// File: tb/tb_sc_char_uart.sv
module tb_sc_char_uart;
  localparam int CLK_P = 10;
  localparam int E = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] etu_div = 8'(E), guard_etu = 8'd0;
  logic proto_t1 = 1'b0, inv_par = 1'b0, tx_mode = 1'b0, wr_tx = 1'b0, last_char = 1'b0;
  logic rd_rx = 1'b0, rd_status = 1'b0, card_low = 1'b0;
  logic [2:0] retry_max = 3'd3, fifo_len = 3'd7;
  logic [7:0] tx_data = 8'd0;
  logic [7:0] rx_data;
  logic [3:0] rx_cnt, status;
  logic io_oe;
  wire io_line = !(io_oe || card_low);

  int n_chk = 0, n_fail = 0, clk_bad = 0;
  bit model_on = 1'b0;
  int q[$];

  sc_char_uart dut (
    .clk(clk), .rst_n(rst_n), .etu_div(etu_div), .guard_etu(guard_etu), .proto_t1(proto_t1),
    .inv_par(inv_par), .retry_max(retry_max), .fifo_len(fifo_len), .tx_mode(tx_mode),
    .wr_tx(wr_tx), .tx_data(tx_data), .last_char(last_char), .rd_rx(rd_rx), .rx_data(rx_data),
    .rx_cnt(rx_cnt), .rd_status(rd_status), .status(status), .io_in(io_line), .io_oe(io_oe)
  );

  always #(CLK_P/2) clk = ~clk;

  always @(negedge clk) if (model_on && int'(rx_cnt) != q.size()) clk_bad++;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic card_send(input logic [7:0] b, input bit badpar, input bit low_guard,
                           output bit nak, output bit nak_after);
    logic [9:0] f;
    f = {(^b) ^ badpar, b, 1'b0};
    model_on = 1'b0;
    nak = 1'b0; nak_after = 1'b0;
    for (int n = 0; n < 13*E; n++) begin
      @(negedge clk);
      if (n < 10*E) card_low = !f[n/E];
      else card_low = low_guard && n < 11*E;
      if (n == 10*E + E/2 + 4) nak = io_oe;
      if (n == 12*E) nak_after = io_oe;
    end
    card_low = 1'b0;
  endtask

  task automatic tx_send(input logic [7:0] b, input bit last, input int naks, input int frames,
                         output int bad, output bit rdy_early, output bit rdy_end);
    logic [9:0] fr;
    int d;
    bit exp;
    fr = {(^b) ^ inv_par, b, 1'b0};
    d = ((proto_t1 ? 10 : 11) + int'(guard_etu)) * E + (E * 4) / 5;
    bad = 0; rdy_early = 1'b0;
    @(negedge clk);
    tx_data = b; last_char = last; wr_tx = 1'b1;
    @(negedge clk);
    wr_tx = 1'b0;
    for (int fi = 0; fi < frames; fi++) begin
      for (int t = 0; t < d; t++) begin
        exp = (t < 10*E) ? !fr[t/E] : 1'b0;
        if (io_oe != exp) bad++;
        card_low = (fi < naks) && t >= 10*E && t < 12*E;
        if (fi == frames - 1 && t == d - 1) rdy_early = status[0];
        @(negedge clk);
      end
    end
    card_low = 1'b0;
    rdy_end = status[0];
  endtask

  task automatic read_one(input string req);
    int e;
    model_on = 1'b0;
    @(negedge clk);
    e = q.pop_front();
    chk(rx_data == 8'(e), req, "fifo head", rx_data, e);
    rd_rx = 1'b1;
    @(negedge clk);
    rd_rx = 1'b0;
    model_on = 1'b1;
  endtask

  task automatic clr_status();
    @(negedge clk); rd_status = 1'b1;
    @(negedge clk); rd_status = 1'b0;
  endtask

  initial begin
    #(CLK_P * 200000);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    bit nk, nk2, r0, r1;
    int bad;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(status == 4'h0, "R1", "status", status, 0);
    chk(rx_cnt == 4'd0, "R1", "rx_cnt", rx_cnt, 0);
    chk(io_oe == 1'b0, "R1", "io_oe", io_oe, 0);

    card_send(8'hA5, 0, 0, nk, nk2); q.push_back(8'hA5);
    chk(nk == 1'b0, "R4", "no refusal of good char", nk, 0);
    card_send(8'h3C, 0, 0, nk, nk2); q.push_back(8'h3C);
    model_on = 1'b1;
    chk(rx_cnt == 4'd2 && status[0] == 1'b0, "R8", "count after two", rx_cnt, 2);

    model_on = 1'b0;
    @(negedge clk); card_low = 1'b1;
    repeat (3) @(negedge clk);
    card_low = 1'b0;
    repeat (3*E) @(negedge clk);
    model_on = 1'b1;
    chk(rx_cnt == 4'd2 && status == 4'h0, "R4", "glitch rejected", {rx_cnt, status}, 8'h20);

    card_send(8'h5A, 1, 0, nk, nk2);
    model_on = 1'b1;
    chk(nk == 1'b1, "R5", "refusal driven", nk, 1);
    chk(nk2 == 1'b0, "R5", "refusal released", nk2, 0);
    chk(status[3] == 1'b1 && rx_cnt == 4'd2, "R5", "pe set, not stored", {status, rx_cnt}, 8'h82);
    clr_status();
    chk(status[3:1] == 3'b000, "R9", "flags cleared", status, 0);

    inv_par = 1'b1;
    card_send(8'h11, 0, 0, nk, nk2);
    chk(nk == 1'b1, "R7", "good char refused", nk, 1);
    card_send(8'h22, 1, 0, nk, nk2); q.push_back(8'h22);
    model_on = 1'b1;
    chk(nk == 1'b0 && rx_cnt == 4'd3, "R7", "bad parity stored", {nk, rx_cnt}, 3);
    inv_par = 1'b0;
    clr_status();

    read_one("R8"); read_one("R8"); read_one("R8");
    chk(rx_cnt == 4'd0, "R8", "drained", rx_cnt, 0);

    proto_t1 = 1'b1;
    card_send(8'h81, 1, 0, nk, nk2); q.push_back(8'h81);
    model_on = 1'b1;
    chk(nk == 1'b0 && status[3] == 1'b1 && rx_cnt == 4'd1, "R11", "T1 bad parity kept",
        {nk, status, rx_cnt}, 9'h081);
    clr_status();
    card_send(8'h42, 0, 1, nk, nk2); q.push_back(8'h42);
    model_on = 1'b1;
    chk(status[1] == 1'b1, "R11", "framing error", status, 2);
    clr_status();
    read_one("R11"); read_one("R11");

    fifo_len = 3'd1;
    card_send(8'h01, 0, 0, nk, nk2); q.push_back(8'h01);
    card_send(8'h02, 0, 0, nk, nk2); q.push_back(8'h02);
    card_send(8'h03, 0, 0, nk, nk2);
    model_on = 1'b1;
    chk(rx_cnt == 4'd2 && status[2] == 1'b1, "R8", "overrun drop", {rx_cnt, status}, 8'h25);
    chk(status[0] == 1'b1, "R9", "rx ready means full", status[0], 1);
    read_one("R8"); read_one("R8");
    clr_status();
    fifo_len = 3'd7;

    @(negedge clk); tx_mode = 1'b1; guard_etu = 8'd2;
    @(negedge clk);
    chk(status[0] == 1'b1, "R10", "ready on switch", status[0], 1);
    tx_send(8'h6B, 0, 0, 1, bad, r0, r1);
    chk(bad == 0, "R2", "T1 frame waveform", bad, 0);
    chk(r0 == 1'b0 && r1 == 1'b1, "R3", "T1 guard spacing", {r0, r1}, 1);

    proto_t1 = 1'b0; guard_etu = 8'd0;
    tx_send(8'hC3, 0, 0, 1, bad, r0, r1);
    chk(bad == 0, "R2", "T0 frame waveform", bad, 0);
    chk(r0 == 1'b0 && r1 == 1'b1, "R3", "T0 spacing", {r0, r1}, 1);

    retry_max = 3'd2;
    tx_send(8'h96, 0, 5, 3, bad, r0, r1);
    chk(bad == 0, "R6", "three attempts", bad, 0);
    chk(status[3] == 1'b1 && r1 == 1'b1, "R6", "pe after retries", {status[3], r1}, 3);
    clr_status();
    tx_send(8'h5E, 0, 1, 2, bad, r0, r1);
    chk(bad == 0 && status[3] == 1'b0, "R6", "one resend succeeds", {bad, status[3]}, 0);

    inv_par = 1'b1;
    tx_send(8'h0F, 0, 0, 1, bad, r0, r1);
    chk(bad == 0, "R7", "inverted parity sent", bad, 0);
    inv_par = 1'b0;

    tx_send(8'hE7, 1, 0, 1, bad, r0, r1);
    chk(bad == 0 && r1 == 1'b0, "R10", "last char leaves ready low", {bad, r1}, 0);

    @(negedge clk); tx_mode = 1'b0;
    @(negedge clk);
    chk(status[0] == 1'b0, "R9", "ready is fifo full in rx", status[0], 0);
    chk(clk_bad == 0, "R8", "per-cycle count model", clk_bad, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule